// File: doc/BRIEF.md
# Descriptor Arbiter with Atomic Pipe Locking

This block sits between a set of unidirectional DMA pipes and one shared peripheral. Each pipe presents the descriptor at the head of its queue, a flag field plus an address/length payload, with a valid/ready handshake. The arbiter picks one pipe per cycle and passes that pipe's descriptor straight through to an execution port, which takes it with its own ready. The pipes are split evenly between two host processors, and the host that owns the granted pipe is reported on the execution port.

Command descriptors carry control flags. One flag claims the peripheral for a single pipe so that its run of commands cannot be interleaved with any other pipe. A second flag ends such a run, and the claim is released only once the peripheral acknowledges that the closing command has completed. A third flag holds back the issuing pipe until that acknowledge arrives. These three flags have no effect on data descriptors. Any descriptor may request an interrupt. The interrupt is given as a one-cycle pulse and as a sticky per-pipe status bit that is cleared by writing 1 to it. With no claim in force, pipes are served in rotation.

Top module: `desc_lock_arbiter`

## Requirements
- R1: After reset no lock is held, no completion wait is pending, `irq_pulse` and `irq_status` are all zero, and the rotation pointer selects pipe 0 first.
- R2: `exe_valid` is high exactly when some pipe is eligible. At most one `pipe_ready` bit is high, and only together with `exe_valid` and `exe_ready` and that pipe's `pipe_valid`. `exe_payload` is the granted pipe's payload.
- R3: With no lock held, the grant goes to the first eligible pipe in rotation order, starting after the pipe most recently accepted. The pointer moves only when a descriptor is accepted.
- R4: Flag encoding: bit0 command, bit1 interrupt, bit2 notify-when-done, bit3 lock, bit4 unlock, bit5 end-of-transfer. When a command descriptor with the lock bit is accepted, `lock_active` rises and `lock_owner` names that pipe. From then on only the owner may be granted.
- R5: When a command descriptor with the unlock bit is accepted, no pipe is granted until `exe_done`. The lock is released on that acknowledge.
- R6: When a command descriptor with the notify-when-done bit is accepted, the issuing pipe is not granted until `exe_done`. Any other pipe whose head also needs an acknowledge (notify-when-done or unlock) is held as well. Pipes with other heads continue to be served.
- R7: A descriptor with the interrupt bit raises its pipe's bit of `irq_pulse` for exactly one cycle and sets the same bit of `irq_status`. This happens in the cycle after acceptance, or in the cycle after `exe_done` if the descriptor waits for an acknowledge. Writing 1 to an `irq_clear` bit clears the matching status bit.
- R8: The lock, unlock and notify-when-done bits have no effect on a data descriptor (command bit 0).
- R9: `exe_host` is the granted pipe index divided by the pipes per host. `exe_cmd` follows the command bit. `exe_eot` is the end-of-transfer bit of a data descriptor and is 0 on a command descriptor.
- R10: An `exe_done` that arrives while no acknowledge is pending changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_valid | input | NUM_PIPES | Head descriptor present, one bit per pipe |
| pipe_flags | input | NUM_PIPES*6 | Flag fields, pipe i at bits [6i+5:6i] |
| pipe_payload | input | NUM_PIPES*PAY_W | Address/length fields, pipe i at slice i |
| pipe_ready | output | NUM_PIPES | Head descriptor taken this cycle |
| exe_valid | output | 1 | A descriptor is offered to the peripheral |
| exe_ready | input | 1 | Peripheral accepts the offered descriptor |
| exe_pipe | output | IDX_W | Index of the granted pipe |
| exe_host | output | HOST_W | Host owning the granted pipe |
| exe_cmd | output | 1 | Offered descriptor is a command |
| exe_eot | output | 1 | Last data descriptor of a write transfer |
| exe_payload | output | PAY_W | Address/length of the offered descriptor |
| exe_done | input | 1 | Peripheral finished the descriptor awaiting acknowledge |
| irq_pulse | output | NUM_PIPES | One-cycle interrupt event per pipe |
| irq_status | output | NUM_PIPES | Sticky interrupt status per pipe |
| irq_clear | input | NUM_PIPES | Write-1-to-clear for irq_status |
| lock_active | output | 1 | A pipe holds the atomic lock |
| lock_owner | output | IDX_W | Pipe holding the lock |

## Verification
The assertions watch the handshake invariants on every cycle: a single ready, a ready only with an offer, no ready against an empty pipe, grants held to the lock owner, a full stall during a pending unlock, the stalled notify-when-done pipe never granted, the lock dropping only on an acknowledge, and an acknowledge with nothing pending leaving the lock alone. The rotation order, which host the payload is routed to, when the interrupt pulse occurs relative to acceptance or acknowledge, write-1-clear, and whether flags on data descriptors are ignored all depend on stimulus history. The directed scenarios show these.

// File: rtl/dla_pkg.sv
package dla_pkg;

  localparam int FLAG_W = 6;

  // Raw flag layout, MSB first: bit5 eot .. bit0 cmd
  typedef struct packed {
    logic eot;
    logic unlock;
    logic lock;
    logic nwd;
    logic irq;
    logic cmd;
  } flags_t;

  // Decoded control after command-only gating
  typedef struct packed {
    logic is_cmd;
    logic want_int;
    logic stall;
    logic take_lock;
    logic drop_lock;
    logic last_beat;
  } ctl_t;

  function automatic ctl_t decode_flags(input flags_t f);
    ctl_t c;
    c.is_cmd    = f.cmd;
    c.want_int  = f.irq;
    c.stall     = f.cmd & f.nwd;
    c.take_lock = f.cmd & f.lock;
    c.drop_lock = f.cmd & f.unlock;
    c.last_beat = ~f.cmd & f.eot;
    return c;
  endfunction

  function automatic logic needs_done(input ctl_t c);
    return c.stall | c.drop_lock;
  endfunction

endpackage

// File: rtl/dla_decode.sv
module dla_decode
  import dla_pkg::*;
(
  input  logic [FLAG_W-1:0] raw_flags,
  output ctl_t              ctl
);
  assign ctl = decode_flags(flags_t'(raw_flags));
endmodule

// File: rtl/dla_rr_pick.sv
module dla_rr_pick #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic [N-1:0]     grant_oh,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_any
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    grant_idx = '0;
    grant_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!grant_any && req[idx]) begin
        grant_any = 1'b1;
        grant_idx = IDX_W'(idx);
      end
    end
    grant_oh = grant_any ? (N'(1) << grant_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IDX_W'(N - 1);
    else if (advance) last_q <= grant_idx;
  end
endmodule

// File: rtl/dla_lock_ctrl.sv
module dla_lock_ctrl
  import dla_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] acc_idx,
  input  ctl_t             acc_ctl,
  input  logic             exe_done,
  output logic             lock_valid,
  output logic [IDX_W-1:0] lock_owner,
  output logic             wait_valid,
  output logic             wait_all,
  output logic             wait_int,
  output logic [IDX_W-1:0] wait_pipe,
  output logic             done_fire
);
  assign done_fire = exe_done & wait_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_valid <= 1'b0;
      lock_owner <= '0;
      wait_valid <= 1'b0;
      wait_all   <= 1'b0;
      wait_int   <= 1'b0;
      wait_pipe  <= '0;
    end else begin
      if (accept) begin
        if (acc_ctl.take_lock) begin
          lock_valid <= 1'b1;
          lock_owner <= acc_idx;
        end
        if (needs_done(acc_ctl)) begin
          wait_valid <= 1'b1;
          wait_all   <= acc_ctl.drop_lock;
          wait_int   <= acc_ctl.want_int;
          wait_pipe  <= acc_idx;
        end
      end
      // eligibility masking keeps accept from arming a wait while one is open
      if (done_fire) begin
        wait_valid <= 1'b0;
        wait_all   <= 1'b0;
        wait_int   <= 1'b0;
        if (wait_all) lock_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dla_irq_track.sv
module dla_irq_track
  import dla_pkg::*;
#(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] acc_idx,
  input  ctl_t             acc_ctl,
  input  logic             done_fire,
  input  logic             wait_int,
  input  logic [IDX_W-1:0] wait_pipe,
  input  logic [N-1:0]     irq_clear,
  output logic [N-1:0]     irq_pulse,
  output logic [N-1:0]     irq_status
);
  logic [N-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (accept && acc_ctl.want_int && !needs_done(acc_ctl))
      set_vec[acc_idx] = 1'b1;
    if (done_fire && wait_int)
      set_vec[wait_pipe] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= '0;
      irq_status <= '0;
    end else begin
      irq_pulse  <= set_vec;
      irq_status <= (irq_status & ~irq_clear) | set_vec;
    end
  end
endmodule

// File: rtl/desc_lock_arbiter.sv
module desc_lock_arbiter
  import dla_pkg::*;
#(
  parameter int  NUM_HOSTS      = 2,
  parameter int  PIPES_PER_HOST = 3,
  parameter int  PAY_W          = 32,
  localparam int NUM_PIPES      = NUM_HOSTS * PIPES_PER_HOST,
  localparam int IDX_W          = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
  localparam int HOST_W         = (NUM_HOSTS > 1) ? $clog2(NUM_HOSTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PIPES-1:0]        pipe_valid,
  input  logic [NUM_PIPES*FLAG_W-1:0] pipe_flags,
  input  logic [NUM_PIPES*PAY_W-1:0]  pipe_payload,
  output logic [NUM_PIPES-1:0]        pipe_ready,
  output logic                        exe_valid,
  input  logic                        exe_ready,
  output logic [IDX_W-1:0]            exe_pipe,
  output logic [HOST_W-1:0]           exe_host,
  output logic                        exe_cmd,
  output logic                        exe_eot,
  output logic [PAY_W-1:0]            exe_payload,
  input  logic                        exe_done,
  output logic [NUM_PIPES-1:0]        irq_pulse,
  output logic [NUM_PIPES-1:0]        irq_status,
  input  logic [NUM_PIPES-1:0]        irq_clear,
  output logic                        lock_active,
  output logic [IDX_W-1:0]            lock_owner
);

  function automatic logic [HOST_W-1:0] host_of(input logic [IDX_W-1:0] p);
    return HOST_W'(int'(p) / PIPES_PER_HOST);
  endfunction

  ctl_t             ctl_arr [NUM_PIPES];
  logic [PAY_W-1:0] pay_arr [NUM_PIPES];
  logic [NUM_PIPES-1:0] eligible;
  logic [NUM_PIPES-1:0] grant_oh;
  logic [IDX_W-1:0]     grant_idx;
  logic                 grant_any;
  logic                 accept;
  ctl_t                 sel_ctl;

  // Named internal events, also observed by the bound checker
  logic             wait_active;
  logic             wait_all;
  logic             wait_int;
  logic [IDX_W-1:0] wait_pipe;
  logic             done_fire;

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    logic lock_ok;
    logic wait_ok;

    dla_decode u_dec (
      .raw_flags (pipe_flags[i*FLAG_W +: FLAG_W]),
      .ctl       (ctl_arr[i])
    );

    assign pay_arr[i] = pipe_payload[i*PAY_W +: PAY_W];
    assign lock_ok    = !lock_active || (lock_owner == IDX_W'(i));
    assign wait_ok    = !wait_active ||
                        (!wait_all && (wait_pipe != IDX_W'(i)) && !needs_done(ctl_arr[i]));
    assign eligible[i] = pipe_valid[i] && lock_ok && wait_ok;
  end

  dla_rr_pick #(.N(NUM_PIPES), .IDX_W(IDX_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (eligible),
    .advance   (accept),
    .grant_oh  (grant_oh),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  assign accept     = grant_any & exe_ready;
  assign pipe_ready = grant_oh & {NUM_PIPES{exe_ready}};
  assign sel_ctl    = ctl_arr[grant_idx];

  always_comb begin
    exe_valid   = grant_any;
    exe_pipe    = grant_idx;
    exe_host    = '0;
    exe_cmd     = 1'b0;
    exe_eot     = 1'b0;
    exe_payload = '0;
    if (grant_any) begin
      exe_host    = host_of(grant_idx);
      exe_cmd     = sel_ctl.is_cmd;
      exe_eot     = sel_ctl.last_beat;
      exe_payload = pay_arr[grant_idx];
    end
  end

  dla_lock_ctrl #(.IDX_W(IDX_W)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .acc_idx    (grant_idx),
    .acc_ctl    (sel_ctl),
    .exe_done   (exe_done),
    .lock_valid (lock_active),
    .lock_owner (lock_owner),
    .wait_valid (wait_active),
    .wait_all   (wait_all),
    .wait_int   (wait_int),
    .wait_pipe  (wait_pipe),
    .done_fire  (done_fire)
  );

  dla_irq_track #(.N(NUM_PIPES), .IDX_W(IDX_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .acc_idx    (grant_idx),
    .acc_ctl    (sel_ctl),
    .done_fire  (done_fire),
    .wait_int   (wait_int),
    .wait_pipe  (wait_pipe),
    .irq_clear  (irq_clear),
    .irq_pulse  (irq_pulse),
    .irq_status (irq_status)
  );

endmodule

// File: rtl/desc_lock_arbiter_chk.sv
module desc_lock_arbiter_chk #(
  parameter int NUM_PIPES = 6,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PIPES-1:0] pipe_valid,
  input logic [NUM_PIPES-1:0] pipe_ready,
  input logic                 exe_valid,
  input logic                 exe_ready,
  input logic                 exe_done,
  input logic                 lock_active,
  input logic [IDX_W-1:0]     lock_owner,
  input logic                 wait_active,
  input logic                 wait_all,
  input logic [IDX_W-1:0]     wait_pipe,
  input logic [NUM_PIPES-1:0] irq_pulse,
  input logic [NUM_PIPES-1:0] irq_status
);

  p_single_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pipe_ready));

  p_ready_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|pipe_ready) |-> (exe_valid && exe_ready));

  p_ready_has_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_ready & ~pipe_valid) == '0);

  p_owner_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && (|pipe_ready)) |-> pipe_ready[lock_owner]);

  p_release_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_all |-> (pipe_ready == '0));

  p_release_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_active) |-> $past(exe_done));

  p_nwd_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active |-> !pipe_ready[wait_pipe]);

  p_pulse_sets_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~irq_status) == '0);

  p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_done && !wait_active && lock_active) |=> lock_active);

endmodule

bind desc_lock_arbiter desc_lock_arbiter_chk #(
  .NUM_PIPES (NUM_PIPES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pipe_valid  (pipe_valid),
  .pipe_ready  (pipe_ready),
  .exe_valid   (exe_valid),
  .exe_ready   (exe_ready),
  .exe_done    (exe_done),
  .lock_active (lock_active),
  .lock_owner  (lock_owner),
  .wait_active (wait_active),
  .wait_all    (wait_all),
  .wait_pipe   (wait_pipe),
  .irq_pulse   (irq_pulse),
  .irq_status  (irq_status)
);

// File: tb/test_desc_lock_arbiter.sv
module test_desc_lock_arbiter;
  localparam int NP = 6;
  localparam int FW = 6;
  localparam int PW = 32;

  localparam logic [5:0] F_CMD  = 6'h01;
  localparam logic [5:0] F_INT  = 6'h02;
  localparam logic [5:0] F_NWD  = 6'h04;
  localparam logic [5:0] F_LOCK = 6'h08;
  localparam logic [5:0] F_UNL  = 6'h10;
  localparam logic [5:0] F_EOT  = 6'h20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NP-1:0]    pipe_valid;
  logic [NP*FW-1:0] pipe_flags;
  logic [NP*PW-1:0] pipe_payload;
  logic [NP-1:0]    pipe_ready;
  logic             exe_valid;
  logic             exe_ready;
  logic [2:0]       exe_pipe;
  logic [0:0]       exe_host;
  logic             exe_cmd;
  logic             exe_eot;
  logic [PW-1:0]    exe_payload;
  logic             exe_done;
  logic [NP-1:0]    irq_pulse;
  logic [NP-1:0]    irq_status;
  logic [NP-1:0]    irq_clear;
  logic             lock_active;
  logic [2:0]       lock_owner;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  desc_lock_arbiter i_desc_lock_arbiter (
    .clk(clk), .rst_n(rst_n),
    .pipe_valid(pipe_valid), .pipe_flags(pipe_flags), .pipe_payload(pipe_payload),
    .pipe_ready(pipe_ready), .exe_valid(exe_valid), .exe_ready(exe_ready),
    .exe_pipe(exe_pipe), .exe_host(exe_host), .exe_cmd(exe_cmd), .exe_eot(exe_eot),
    .exe_payload(exe_payload), .exe_done(exe_done),
    .irq_pulse(irq_pulse), .irq_status(irq_status), .irq_clear(irq_clear),
    .lock_active(lock_active), .lock_owner(lock_owner)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_head(input int p, input logic [5:0] f, input logic [31:0] pay);
    pipe_valid[p]            = 1'b1;
    pipe_flags[p*FW +: FW]   = f;
    pipe_payload[p*PW +: PW] = pay;
  endtask

  task automatic drop(input int p);
    pipe_valid[p] = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pipe_valid = '0; pipe_flags = '0; pipe_payload = '0;
    exe_ready = 1'b0; exe_done = 1'b0; irq_clear = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 lock_active", 32'(lock_active), 0);
    chk("R1 irq_status", 32'(irq_status), 0);
    chk("R1 irq_pulse", 32'(irq_pulse), 0);
    chk("R2 idle exe_valid", 32'(exe_valid), 0);
  endtask

  task automatic t_rotation();
    do_reset();
    set_head(0, 6'h00, 32'hA0); set_head(2, 6'h00, 32'hA2); set_head(4, 6'h00, 32'hA4);
    #1;
    chk("R2 offer without ready", 32'(exe_valid), 1);
    chk("R2 no ready when exe not ready", 32'(pipe_ready), 0);
    chk("R1 first pick pipe0", 32'(exe_pipe), 0);
    tick(); #1;
    chk("R3 no advance without accept", 32'(exe_pipe), 0);
    exe_ready = 1'b1; #1;
    chk("R2 single ready", 32'(pipe_ready), 32'h01);
    chk("R2 payload mux", exe_payload, 32'hA0);
    tick(); #1;
    chk("R3 next pipe2", 32'(exe_pipe), 2);
    chk("R2 payload pipe2", exe_payload, 32'hA2);
    chk("R9 host of pipe2", 32'(exe_host), 0);
    tick(); #1;
    chk("R3 next pipe4", 32'(exe_pipe), 4);
    chk("R9 host of pipe4", 32'(exe_host), 1);
    tick(); #1;
    chk("R3 wrap to pipe0", 32'(exe_pipe), 0);
  endtask

  task automatic t_lock_unlock();
    do_reset();
    exe_ready = 1'b1;
    set_head(1, F_CMD | F_LOCK, 32'h100); set_head(3, 6'h00, 32'h300); #1;
    chk("R4 lock cmd granted", 32'(exe_pipe), 1);
    tick();
    set_head(1, F_CMD, 32'h101); #1;
    chk("R4 lock_active", 32'(lock_active), 1);
    chk("R4 lock_owner", 32'(lock_owner), 1);
    chk("R4 owner keeps grant", 32'(exe_pipe), 1);
    tick(); #1;
    chk("R4 other pipe blocked", 32'(exe_pipe), 1);
    set_head(1, F_CMD | F_UNL, 32'h102); #1;
    chk("R4 owner unlock offered", 32'(exe_pipe), 1);
    tick();
    drop(1); #1;
    chk("R5 stall after unlock", 32'(exe_valid), 0);
    chk("R5 lock held until done", 32'(lock_active), 1);
    tick(); #1;
    chk("R5 still stalled", 32'(exe_valid), 0);
    exe_done = 1'b1;
    tick();
    exe_done = 1'b0; #1;
    chk("R5 lock released", 32'(lock_active), 0);
    chk("R5 other pipe served", 32'(exe_pipe), 3);
    chk("R5 offer resumes", 32'(exe_valid), 1);
  endtask

  task automatic t_nwd();
    do_reset();
    exe_ready = 1'b1;
    set_head(2, F_CMD | F_NWD, 32'h20); #1;
    chk("R6 nwd cmd granted", 32'(exe_pipe), 2);
    tick();
    set_head(2, 6'h00, 32'h21); #1;
    chk("R6 issuing pipe stalled", 32'(exe_valid), 0);
    set_head(4, F_CMD | F_NWD, 32'h40); #1;
    chk("R6 second nwd held", 32'(exe_valid), 0);
    set_head(0, 6'h00, 32'h0); #1;
    chk("R6 plain head still served", 32'(exe_pipe), 0);
    drop(0);
    exe_done = 1'b1;
    tick();
    exe_done = 1'b0; #1;
    chk("R6 released after done", 32'(exe_pipe), 4);
  endtask

  task automatic t_irq();
    do_reset();
    exe_ready = 1'b1;
    set_head(3, F_INT, 32'h33);
    tick();
    drop(3); #1;
    chk("R7 pulse after accept", 32'(irq_pulse), 32'h08);
    chk("R7 status set", 32'(irq_status), 32'h08);
    tick(); #1;
    chk("R7 pulse one cycle", 32'(irq_pulse), 0);
    chk("R7 status sticky", 32'(irq_status), 32'h08);
    irq_clear = 6'h08;
    tick();
    irq_clear = '0; #1;
    chk("R7 write-1 clear", 32'(irq_status), 0);
    set_head(0, F_CMD | F_NWD | F_INT, 32'h5);
    tick();
    drop(0); #1;
    chk("R7 no pulse before done", 32'(irq_pulse), 0);
    exe_done = 1'b1;
    tick();
    exe_done = 1'b0; #1;
    chk("R7 pulse after done", 32'(irq_pulse), 32'h01);
  endtask

  task automatic t_data_flags();
    do_reset();
    exe_ready = 1'b1;
    set_head(1, F_LOCK | F_NWD | F_UNL, 32'h11);
    tick(); #1;
    chk("R8 no lock from data", 32'(lock_active), 0);
    chk("R8 no stall from data", 32'(exe_valid), 1);
    chk("R8 same pipe reissued", 32'(exe_pipe), 1);
  endtask

  task automatic t_fields();
    do_reset();
    set_head(2, F_EOT, 32'h7); #1;
    chk("R9 eot on data", 32'(exe_eot), 1);
    chk("R9 cmd clear", 32'(exe_cmd), 0);
    set_head(2, F_CMD | F_EOT, 32'h7); #1;
    chk("R9 eot masked on cmd", 32'(exe_eot), 0);
    chk("R9 cmd set", 32'(exe_cmd), 1);
  endtask

  task automatic t_stray_done();
    do_reset();
    exe_ready = 1'b1;
    set_head(0, F_CMD | F_LOCK, 32'h1);
    tick();
    drop(0);
    exe_done = 1'b1;
    tick();
    exe_done = 1'b0; #1;
    chk("R10 lock survives stray done", 32'(lock_active), 1);
    chk("R10 owner unchanged", 32'(lock_owner), 0);
    set_head(5, 6'h00, 32'h5); #1;
    chk("R10 others still blocked", 32'(exe_valid), 0);
  endtask

  initial begin
    t_reset();
    t_rotation();
    t_lock_unlock();
    t_nwd();
    t_irq();
    t_data_flags();
    t_fields();
    t_stray_done();
    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule